// File: doc/BRIEF.md
# Programmable-Skew Triple-Sample Register

This block is a pipeline register that rejects short transients on its data input. Within each slow pipeline period it takes three samples of the same combinational signal, spaced a programmable number of fast-clock ticks apart. The value it presents is the bitwise majority of those three samples. A glitch that is narrower than the spacing can land on one sample at most, so the vote hides it. Raising the spacing widens the transients that are masked. The level of hardening is therefore a setting chosen at run time, not something fixed when the block is built.

The whole block runs on one fast clock. A strobe, high for one fast tick, marks the start of every slow period. The spacing is read from a configuration input at that strobe and nowhere else. A spacing value that would push the vote past the end of the period is pulled back to the largest legal value. A glitch that starts in the voter itself reaches the output register and is then filtered by the next stage's triple-sample register, which works the same way.

Top module: `tsr_skew_register`

## Requirements
- R1: Phase 0 is the fast-clock edge at which `slow_tick` is high. At that edge, and at phases d and 2d after it, `d_in` is sampled, where d is the effective spacing.
- R2: At its update, `q_out` takes the bitwise majority of the three samples: each bit is 1 when at least two of the samples have that bit set.
- R3: A transient that changes `d_in` at only one of the three sample phases has no effect on `q_out`.
- R4: A transient that lasts fewer than d consecutive ticks corrupts at most one sample and is masked. With d=1, a two-tick transient that covers phases 0 and 1 wins the vote.
- R5: `dt_cfg` is an unsigned count of fast ticks. The effective spacing d is 1 when `dt_cfg` is 0, and (PERIOD-2)/2 (7 for PERIOD=16) when `dt_cfg` is above that limit. Otherwise d equals `dt_cfg`.
- R6: `q_out` resets to 0. It changes only at the edge at phase 2d+1 and holds its value at every other edge.
- R7: `dt_cfg` is captured only at the `slow_tick` edge. A change to it later in the period has no effect on that period's sample phases.
- R8: A `slow_tick` that arrives before the vote restarts the sequence at phase 0. The unfinished vote is dropped, and `q_out` keeps its previous value until the new vote.
- R9: After reset and before the first `slow_tick`, `q_out` stays 0 whatever `d_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-tick strobe at the first fast tick of each slow period |
| dt_cfg | input | DT_W | Requested spacing between samples, in fast ticks |
| d_in | input | DATA_W | Combinational data to be sampled |
| q_out | output | DATA_W | Voted register output |

## Verification
The bench builds the block with DATA_W=8, DT_W=4 and PERIOD=16. With these values the clamp limit is 7, so the 4-bit field spans both clamp regions (0 and 8 to 15) as well as the full legal range. The 16-tick period leaves room for the widest spacing, with its vote at phase 15. Driving a different data value at every phase makes each sample instant visible in the voted result. This shows which phases were sampled and the exact cycle at which the output changes.

// File: rtl/tsr_pkg.sv
`timescale 1ns/1ps
package tsr_pkg;

  // Largest spacing that still lets the vote land inside the period
  // and fit in the configuration field.
  function automatic int tsr_max_dt(int period, int dt_w);
    int by_period;
    int by_field;
    by_period = (period - 2) / 2;
    by_field  = (1 << dt_w) - 1;
    return (by_period < by_field) ? by_period : by_field;
  endfunction

  // Map a requested spacing onto the legal range [1, hi].
  function automatic int tsr_legal_dt(int raw, int hi);
    if (raw < 1)  return 1;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Phase of the vote for a given spacing.
  function automatic int tsr_vote_phase(int dt);
    return 2 * dt + 1;
  endfunction

endpackage

// File: rtl/tsr_phase_ctrl.sv
`timescale 1ns/1ps
module tsr_phase_ctrl #(
  parameter int DT_W   = 4,
  parameter int PERIOD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_tick,
  input  logic [DT_W-1:0] dt_cfg,
  output logic            en_a,
  output logic            en_b,
  output logic            en_c,
  output logic            vote_en,
  output logic [DT_W-1:0] dt_now
);
  import tsr_pkg::*;

  localparam int MAX_DT = tsr_max_dt(PERIOD, DT_W);
  localparam int PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0] phase_cnt;
  logic            running;
  logic [PH_W-1:0] tgt_b;
  logic [PH_W-1:0] tgt_c;
  logic [PH_W-1:0] tgt_v;

  always_comb begin
    tgt_b = PH_W'(int'(dt_now));
    tgt_c = PH_W'(2 * int'(dt_now));
    tgt_v = PH_W'(tsr_vote_phase(int'(dt_now)));
  end

  assign en_a    = slow_tick;
  assign en_b    = running && !slow_tick && (phase_cnt == tgt_b);
  assign en_c    = running && !slow_tick && (phase_cnt == tgt_c);
  assign vote_en = running && !slow_tick && (phase_cnt == tgt_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dt_now    <= DT_W'(1);
      phase_cnt <= '0;
      running   <= 1'b0;
    end else if (slow_tick) begin
      dt_now    <= DT_W'(tsr_legal_dt(int'(dt_cfg), MAX_DT));
      phase_cnt <= PH_W'(1);
      running   <= 1'b1;
    end else if (running) begin
      phase_cnt <= phase_cnt + PH_W'(1);
      if (vote_en) running <= 1'b0;
    end
  end

  a_r5_dt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dt_now) >= 1) && (int'(dt_now) <= MAX_DT));

  a_r7_dt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(dt_now));

  a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_a, en_b, en_c, vote_en}));

  a_r6_vote_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    vote_en |=> !(en_b || en_c || vote_en));

endmodule

// File: rtl/tsr_sample_bank.sv
`timescale 1ns/1ps
module tsr_sample_bank #(
  parameter int DATA_W = 8,
  parameter int N_SMP  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SMP-1:0]             take,
  input  logic [DATA_W-1:0]            d_in,
  output logic [N_SMP-1:0][DATA_W-1:0] smp
);

  for (genvar g = 0; g < N_SMP; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)       smp[g] <= '0;
      else if (take[g]) smp[g] <= d_in;
    end

    a_r1_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !take[g] |=> $stable(smp[g]));
  end

endmodule

// File: rtl/tsr_vote_stage.sv
`timescale 1ns/1ps
module tsr_vote_stage #(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vote_en,
  input  logic [2:0][DATA_W-1:0]   smp,
  output logic [DATA_W-1:0]        q
);

  function automatic logic [DATA_W-1:0] majority3(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y,
    input logic [DATA_W-1:0] z
  );
    return (x & y) | (x & z) | (y & z);
  endfunction

  logic [DATA_W-1:0] voted;
  assign voted = majority3(smp[0], smp[1], smp[2]);

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (vote_en) q <= voted;
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_en |=> $stable(q));

  a_r2_pair_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_en && (smp[0] == smp[1])) |=> (q == $past(smp[0])));

  a_r3_outlier_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_en && (smp[1] == smp[2])) |=> (q == $past(smp[2])));

endmodule

// File: rtl/tsr_skew_register.sv
`timescale 1ns/1ps
module tsr_skew_register #(
  parameter int DATA_W = 8,
  parameter int DT_W   = 4,
  parameter int PERIOD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [DT_W-1:0]   dt_cfg,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] q_out
);

  logic                   en_a;
  logic                   en_b;
  logic                   en_c;
  logic                   vote_en;
  logic [DT_W-1:0]        dt_now;
  logic [2:0][DATA_W-1:0] smp;

  tsr_phase_ctrl #(.DT_W(DT_W), .PERIOD(PERIOD)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .dt_cfg    (dt_cfg),
    .en_a      (en_a),
    .en_b      (en_b),
    .en_c      (en_c),
    .vote_en   (vote_en),
    .dt_now    (dt_now)
  );

  tsr_sample_bank #(.DATA_W(DATA_W), .N_SMP(3)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .take  ({en_c, en_b, en_a}),
    .d_in  (d_in),
    .smp   (smp)
  );

  tsr_vote_stage #(.DATA_W(DATA_W)) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .vote_en (vote_en),
    .smp     (smp),
    .q       (q_out)
  );

  a_r9_idle_until_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_tick && (q_out == '0) && $past(!rst_n)) |=> (q_out == '0));

endmodule

// File: tb/tsr_skew_register_tb.sv
`timescale 1ns/1ps
module tsr_skew_register_tb;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int PER = 16;
  localparam int LIM = (PER - 2) / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_tick = 1'b0;
  logic [CW-1:0] dt_cfg = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] pat [PER];

  always #4 clk = ~clk;

  tsr_skew_register #(.DATA_W(DW), .DT_W(CW), .PERIOD(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .dt_cfg(dt_cfg), .d_in(d_in), .q_out(q_out)
  );

  function automatic logic [DW-1:0] vote3(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      int ones;
      ones = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (ones >= 2);
    end
    return r;
  endfunction

  function automatic int eff_dt(int c);
    if (c == 0) return 1;
    if (c > LIM) return LIM;
    return c;
  endfunction

  // behavioural reference model
  int            m_ph;
  int            m_dt;
  bit            m_run;
  logic [DW-1:0] m_s [3];
  logic [DW-1:0] m_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_q = '0; m_ph = 0; m_dt = 1;
    end else if (slow_tick) begin
      m_dt = eff_dt(int'(dt_cfg)); m_ph = 0; m_run = 1; m_s[0] = d_in;
    end else if (m_run) begin
      m_ph++;
      if (m_ph == m_dt)     m_s[1] = d_in;
      if (m_ph == 2 * m_dt) m_s[2] = d_in;
      if (m_ph == 2 * m_dt + 1) begin
        m_q = vote3(m_s[0], m_s[1], m_s[2]);
        m_run = 0;
      end
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check("R6 per-cycle model", q_out, m_q);
  end

  // one slow period; optional mid-period cfg change; n ticks with strobe on the first
  task automatic run_ticks(int cfg, int n, int mid_cfg);
    for (int ph = 0; ph < n; ph++) begin
      @(negedge clk);
      slow_tick = (ph == 0);
      if (ph == 0) dt_cfg = CW'(cfg);
      else if (mid_cfg >= 0 && ph == 1) dt_cfg = CW'(mid_cfg);
      d_in = pat[ph];
    end
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic run_period(int cfg, int mid_cfg);
    run_ticks(cfg, PER, mid_cfg);
  endtask

  function automatic logic [DW-1:0] expect_for(int cfg);
    int d;
    d = eff_dt(cfg);
    return vote3(pat[0], pat[d], pat[2 * d]);
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] prev;
    repeat (3) @(negedge clk);
    check("R6 reset value", q_out, 8'h00);
    rst_n = 1'b1;
    // R9: data moves, no strobe
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      d_in = DW'(8'h3C + i * 17);
    end
    @(negedge clk);
    check("R9 idle before first tick", q_out, 8'h00);

    // R1 R2: ramp, d=3
    for (int i = 0; i < PER; i++) pat[i] = DW'(8'h10 + i);
    run_period(3, -1);
    check("R1 R2 ramp d=3", q_out, expect_for(3));
    check("R2 majority value", q_out, 8'h12);

    // R3: single-sample glitch
    for (int i = 0; i < PER; i++) pat[i] = 8'hA5;
    pat[3] = 8'h5A;
    run_period(3, -1);
    check("R3 single sample glitch masked", q_out, 8'hA5);

    // R4: two-tick glitch with d=3 masked
    for (int i = 0; i < PER; i++) pat[i] = 8'h00;
    pat[2] = 8'hFF; pat[3] = 8'hFF;
    run_period(3, -1);
    check("R4 short transient masked d=3", q_out, 8'h00);

    // R4: two-tick glitch with d=1 wins
    for (int i = 0; i < PER; i++) pat[i] = 8'h00;
    pat[0] = 8'hFF; pat[1] = 8'hFF;
    run_period(1, -1);
    check("R4 transient wins at d=1", q_out, 8'hFF);

    // R5: clamp high
    for (int i = 0; i < PER; i++) pat[i] = DW'(i);
    run_period(12, -1);
    check("R5 clamp cfg=12", q_out, 8'h06);
    pat[0] = 8'h01;
    run_period(15, -1);
    check("R5 clamp cfg=15", q_out, vote3(8'h01, 8'h07, 8'h0E));

    // R5: zero treated as one
    for (int i = 0; i < PER; i++) pat[i] = 8'h00;
    pat[0] = 8'h0F; pat[1] = 8'h3C; pat[2] = 8'hF0;
    run_period(0, -1);
    check("R5 cfg=0 acts as 1", q_out, 8'h3C);

    // R7: mid-period cfg change ignored
    for (int i = 0; i < PER; i++) pat[i] = DW'(i * 3 + 1);
    run_period(2, 5);
    check("R7 mid-period cfg ignored", q_out, vote3(pat[0], pat[2], pat[4]));

    // R6: hold without strobe
    prev = q_out;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      d_in = DW'(i * 29);
    end
    @(negedge clk);
    check("R6 hold between periods", q_out, prev);

    // R8: restart before vote
    for (int i = 0; i < PER; i++) pat[i] = 8'hEE;
    prev = q_out;
    run_ticks(3, 4, -1);
    check("R8 abandoned vote keeps output", q_out, prev);
    for (int i = 0; i < PER; i++) pat[i] = 8'h77;
    run_period(3, -1);
    check("R8 restarted vote", q_out, 8'h77);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule